// File: doc/BRIEF.md
# GF(2^233) Trinomial Modular Reducer

This block turns the unreduced carry-less product of two elements of the binary field GF(2^233) back into a field element. Its input is the 465-bit polynomial that a full-width carry-less multiplier or a squarer delivers. Its output is the 233-bit remainder of that polynomial modulo the trinomial x^233 + x^74 + 1.

It is purely combinational. It sits between the wide polynomial multiplier and the rest of the field arithmetic unit, and any pipelining is left to the surrounding datapath. The design rests on the identity x^233 = x^74 + 1. Because the middle exponent 74 is less than half of 233, two fixed XOR folding passes are enough to clear every bit at or above position 233, and no iterative division is needed.

The first pass folds input bits 233..464 down, which leaves a value of at most 306 bits. The second pass folds bits 233..305 of that value, and the result then fits in 233 bits.

Top module: `gf233_reducer`

## Requirements
- R1: For any 465-bit input, `elem_o` equals the remainder of the input polynomial (bit i is the coefficient of x^i) divided by x^233 + x^74 + 1 over GF(2).
- R2: When input bits 233..464 are all zero, `elem_o` equals input bits 0..232 unchanged.
- R3: An input equal to x^233 alone (only bit 233 set) gives an output with exactly bits 0 and 74 set.
- R4: An input equal to x^464 alone (only bit 464 set) gives an output with exactly bits 72, 146 and 231 set.
- R5: A single set input bit i with 233 <= i <= 391 gives exactly two output bits, at positions i-233 and i-159.
- R6: The first folding pass yields an intermediate value of 306 bits. When its bits 233..305 are zero, the second pass passes its bits 0..232 through to `elem_o` unchanged.
- R7: The reduction is linear: the output for input a XOR b equals the XOR of the outputs for a and for b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| prod_i | input | 465 | Unreduced carry-less product; bit i is the coefficient of x^i |
| elem_o | output | 233 | Reduced field element; bit i is the coefficient of x^i |

## Verification
The hardest case to reach is an input bit that the first pass cannot clear. Input bits 392..464 fold onto positions 233..305, and only the second pass reduces them. Random operands rarely isolate such a bit in a way that would reveal a wrong shift in that pass. The stimulus therefore sweeps every single upper bit from 233 to 464, including the top bit 464. It then applies dense random values whose upper half is full, and compares each result with a bit-serial long-division reference.

// File: rtl/gf233_pkg.sv
package gf233_pkg;
  // Field degree and middle exponent of the reduction trinomial
  localparam int unsigned FIELD_M = 233;
  localparam int unsigned FIELD_N = 74;
  // Width of an unreduced product of two field elements
  localparam int unsigned PROD_W  = 2 * FIELD_M - 1;
endpackage

// File: rtl/gf233_fold.sv
// One folding pass: every bit at position i >= M is moved to i-M and i-M+N.
module gf233_fold #(
  parameter int unsigned M  = 233,
  parameter int unsigned N  = 74,
  parameter int unsigned WI = 465,
  parameter int unsigned WO = 306
) (
  input  logic [WI-1:0] in_i,
  output logic [WO-1:0] out_o
);
  localparam int unsigned HW = WI - M;

  logic [HW-1:0] hi;
  logic [WO-1:0] lo_ext;
  logic [WO-1:0] hi_ext;

  always_comb begin
    hi     = in_i[WI-1:M];
    lo_ext = WO'(in_i[M-1:0]);
    hi_ext = WO'(hi);
    out_o  = lo_ext ^ hi_ext ^ (hi_ext << N);
  end
endmodule

// File: rtl/gf233_reducer.sv
module gf233_reducer #(
  parameter int unsigned M = gf233_pkg::FIELD_M,
  parameter int unsigned N = gf233_pkg::FIELD_N
) (
  input  logic [2*M-2:0] prod_i,
  output logic [M-1:0]   elem_o
);
  localparam int unsigned PW  = 2 * M - 1;
  // Highest reach of the first pass: (PW-1) - M + N, plus one for width
  localparam int unsigned F1W = PW - M + N;

  logic [F1W-1:0] fold1_w;

  gf233_fold #(.M(M), .N(N), .WI(PW), .WO(F1W)) u_fold1 (
    .in_i  (prod_i),
    .out_o (fold1_w)
  );

  // Second pass clears what the first left above M-1 (N < M/2 keeps it within M bits)
  gf233_fold #(.M(M), .N(N), .WI(F1W), .WO(M)) u_fold2 (
    .in_i  (fold1_w),
    .out_o (elem_o)
  );
endmodule

// File: rtl/gf233_reducer_chk.sv
module gf233_reducer_chk #(
  parameter int unsigned M   = 233,
  parameter int unsigned N   = 74,
  parameter int unsigned F1W = 306
) (
  input logic [2*M-2:0] prod_i,
  input logic [M-1:0]   elem_o,
  input logic [F1W-1:0] fold1_w
);
  localparam int unsigned PW = 2 * M - 1;

  always_comb begin
    // R2
    upper_zero_pass_chk: assert ((prod_i[PW-1:M] != '0) || (elem_o == prod_i[M-1:0]));
    // R3
    top_identity_chk: assert ((prod_i != (PW'(1) << M)) ||
                              (elem_o == ((M'(1) << N) | M'(1))));
    // R5
    single_fold_chk: assert (!(($countones(prod_i) == 1) &&
                               (prod_i[M+M-N-1:M] != '0)) ||
                             ($countones(elem_o) == 2));
    // R6
    second_pass_chk: assert ((fold1_w[F1W-1:M] != '0) || (elem_o == fold1_w[M-1:0]));
    // R6
    fold1_low_pass_chk: assert ((prod_i[PW-1:M] != '0) || (fold1_w == F1W'(prod_i[M-1:0])));
  end
endmodule

bind gf233_reducer gf233_reducer_chk #(.M(M), .N(N), .F1W(F1W)) u_chk (
  .prod_i  (prod_i),
  .elem_o  (elem_o),
  .fold1_w (fold1_w)
);

// File: tb/gf233_reducer_tb.sv
module gf233_reducer_tb;
  localparam int unsigned M  = 233;
  localparam int unsigned N  = 74;
  localparam int unsigned PW = 2 * M - 1;

  logic          clk = 1'b0;
  logic [PW-1:0] prod;
  logic [M-1:0]  elem;
  int            checks = 0;
  int            errors = 0;
  bit            done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  gf233_reducer u_dut (.prod_i(prod), .elem_o(elem));

  // Bit-serial long division reference
  function automatic logic [M-1:0] ref_reduce(input logic [PW-1:0] a);
    logic [PW-1:0] r;
    r = a;
    for (int i = PW - 1; i >= M; i--) begin
      if (r[i]) begin
        r[i]         = 1'b0;
        r[i - M + N] = r[i - M + N] ^ 1'b1;
        r[i - M]     = r[i - M] ^ 1'b1;
      end
    end
    return r[M-1:0];
  endfunction

  function automatic logic [PW-1:0] rand_wide();
    logic [PW-1:0] v;
    v = '0;
    for (int k = 0; k < 15; k++) v = (v << 32) | PW'($urandom());
    return v;
  endfunction

  task automatic apply(input logic [PW-1:0] v, output logic [M-1:0] res);
    @(posedge clk);
    prod = v;
    @(negedge clk);
    res = elem;
  endtask

  task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_zero();
    logic [M-1:0] r;
    apply('0, r);
    check("R2 zero input", r, '0);
  endtask

  task automatic t_passthrough();
    logic [M-1:0] r;
    logic [PW-1:0] v;
    for (int k = 0; k < 20; k++) begin
      v = rand_wide() & PW'({M{1'b1}});
      apply(v, r);
      check("R2 low-only input", r, v[M-1:0]);
    end
    apply(PW'({M{1'b1}}), r);
    check("R2 all-ones low", r, {M{1'b1}});
  endtask

  task automatic t_x233();
    logic [M-1:0] r;
    apply(PW'(1) << M, r);
    check("R3 x^233", r, (M'(1) << N) | M'(1));
  endtask

  task automatic t_x464();
    logic [M-1:0] r;
    apply(PW'(1) << (PW - 1), r);
    check("R4 x^464", r, (M'(1) << 231) | (M'(1) << 146) | (M'(1) << 72));
  endtask

  task automatic t_single_bits();
    logic [M-1:0] r;
    logic [M-1:0] e;
    for (int i = M; i < PW; i++) begin
      apply(PW'(1) << i, r);
      if (i <= M + M - N - 1) begin
        e = (M'(1) << (i - M)) | (M'(1) << (i - M + N));
        check("R5 single upper bit", r, e);
      end else begin
        check("R1 single high bit", r, ref_reduce(PW'(1) << i));
      end
    end
  endtask

  task automatic t_random();
    logic [M-1:0] r;
    logic [PW-1:0] v;
    for (int k = 0; k < 300; k++) begin
      v = rand_wide();
      if (k % 3 == 0) v = v | ~(PW'({M{1'b1}}));
      apply(v, r);
      check("R1 random", r, ref_reduce(v));
    end
    apply('1, r);
    check("R1 all ones", r, ref_reduce('1));
  endtask

  task automatic t_linear();
    logic [M-1:0] ra, rb, rx;
    logic [PW-1:0] a, b;
    for (int k = 0; k < 20; k++) begin
      a = rand_wide();
      b = rand_wide();
      apply(a, ra);
      apply(b, rb);
      apply(a ^ b, rx);
      check("R7 linearity", rx, ra ^ rb);
    end
  endtask

  task automatic t_second_pass();
    logic [M-1:0] r;
    logic [PW-1:0] v;
    // R6: bits 392..464 land on 233..305 after the first pass
    v = '0;
    for (int i = M + M - N; i < PW; i += 7) v[i] = 1'b1;
    v = v | PW'(20'hA5C3F);
    apply(v, r);
    check("R6 second pass", r, ref_reduce(v));
  endtask

  initial begin
    prod = '0;
    repeat (3) @(posedge clk);
    t_zero();
    t_passthrough();
    t_x233();
    t_x464();
    t_single_bits();
    t_second_pass();
    t_random();
    t_linear();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule